// File: doc/BRIEF.md
# Dual-Multiplier SIMD Multiply-Accumulate Unit

This block is a multiply-accumulate datapath built around two signed 16x16 multipliers and a 40-bit accumulation result. Each operand word is 32 bits wide and holds two signed 16-bit halves. Every valid cycle the unit applies one of three operations to an incoming accumulator value.

The first operation is a single multiply-accumulate on the high halves. The second adds both the high-half product and the low-half product into one 40-bit sum. The third treats the 40-bit accumulator as two separate 20-bit lanes, and each lane gets its own product. The two multipliers run in parallel, so every mode takes the same single cycle.

The accumulator register file lives outside the block. The caller presents the current accumulator value on `acc_in` and writes the registered `acc_out` back to its own storage. Instruction decode, saturation and extended-precision multiplies belong to the surrounding pipeline.

Top module: `mac_dual_simd`

## Requirements
- R1: With `op` = 2'b00 (single), the result is `acc_in` + hi(a)*hi(b). The halves are hi = bits [31:16] and lo = bits [15:0], and the product is signed two's complement, sign-extended to 40 bits. The low halves of both operands have no effect on the result.
- R2: With `op` = 2'b01 (dual), the result is `acc_in` + hi(a)*hi(b) + lo(a)*lo(b). Both products are signed and sign-extended to 40 bits, and both are added in the same operation.
- R3: With `op` = 2'b10 (SIMD), the accumulator is split into an upper lane, bits [39:20], and a lower lane, bits [19:0]. The upper lane becomes upper + hi(a)*hi(b) and the lower lane becomes lower + lo(a)*lo(b). Each lane keeps only the low 20 bits of its sum, so it wraps modulo 2^20.
- R4: In SIMD mode no carry or borrow passes from the lower lane into the upper lane. A lower-lane overflow or underflow leaves the upper lane exactly as R3 computes it.
- R5: The 40-bit sums in the single and dual modes wrap modulo 2^40.
- R6: With `op` = 2'b11 (pass), the result equals `acc_in` unchanged.
- R7: A result appears on `acc_out` on the rising edge that follows the cycle in which `in_valid` is high. `out_valid` is high in exactly that cycle, so a run of back-to-back valid cycles produces a result every cycle.
- R8: In a cycle with `in_valid` low, `acc_out` keeps its previous value, and in the following cycle `out_valid` is low.
- R9: The reset is synchronous and active-low. While `rst_n` is low at a rising edge, `acc_out` becomes 0 and `out_valid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request for this cycle |
| op | input | 2 | Operation select: 00 single, 01 dual, 10 SIMD, 11 pass |
| opnd_a | input | 32 | First operand, two signed 16-bit halves |
| opnd_b | input | 32 | Second operand, two signed 16-bit halves |
| acc_in | input | 40 | Current accumulator value |
| out_valid | output | 1 | Result on acc_out is new this cycle |
| acc_out | output | 40 | Registered accumulator result |

## Verification
The bench builds the unit with its default widths: 16-bit halves, a 40-bit accumulator and 20-bit lanes. With these widths the bench can hand-compute boundary vectors that hit each corner directly:
- a product of the two most negative halves;
- a 40-bit wrap from all ones;
- a lower lane that overflows and one that underflows, with the upper lane unchanged;
- a high-half product wider than a lane, truncated to its low 20 bits.

Directed cycles cover reset, idle hold and back-to-back issue.

// File: rtl/mac_pkg.sv
// Package: shared widths and the operation encoding of the dual-multiplier MAC.
// Assumes a 40-bit accumulator that holds two equal-width SIMD lanes.
package mac_pkg;
    localparam int unsigned MAC_HALF_W = 16;
    localparam int unsigned MAC_WORD_W = 2 * MAC_HALF_W;
    localparam int unsigned MAC_ACC_W  = 40;

    typedef enum logic [1:0] {
        MAC_OP_SINGLE = 2'b00,
        MAC_OP_DUAL   = 2'b01,
        MAC_OP_SIMD   = 2'b10,
        MAC_OP_PASS   = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_mul_pair.sv
// Module: two parallel signed HALF_W x HALF_W multipliers.
// Lane 0 multiplies the low halves and lane 1 the high halves.
// Assumes operands are two's complement halves packed as {hi, lo}.
module mac_mul_pair #(
    parameter int unsigned HALF_W = mac_pkg::MAC_HALF_W,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned PROD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    output logic [PROD_W-1:0] prod_lo,
    output logic [PROD_W-1:0] prod_hi
);
    logic [PROD_W-1:0] prod_lane [2];

    for (genvar g = 0; g < 2; g++) begin : g_mul
        logic signed [HALF_W-1:0] ha;
        logic signed [HALF_W-1:0] hb;
        logic signed [PROD_W-1:0] pr;

        // Select this lane's halves and form their signed product.
        always_comb begin
            ha = opnd_a[g*HALF_W +: HALF_W];
            hb = opnd_b[g*HALF_W +: HALF_W];
            pr = PROD_W'(ha) * PROD_W'(hb);
        end

        assign prod_lane[g] = pr;
    end

    assign prod_lo = prod_lane[0];
    assign prod_hi = prod_lane[1];
endmodule

// File: rtl/mac_combine.sv
// Module: combines the two products with the accumulator according to the opcode.
// The 40-bit modes sign-extend the products and wrap.
// The SIMD mode adds each product's low LANE_W bits into its own lane, and no
// carry passes between the lanes.
// Assumes ACC_W > PROD_W and LANE_W <= PROD_W.
module mac_combine #(
    parameter int unsigned PROD_W = 2 * mac_pkg::MAC_HALF_W,
    parameter int unsigned ACC_W  = mac_pkg::MAC_ACC_W,
    localparam int unsigned LANE_W = ACC_W / 2,
    localparam int unsigned EXT_W  = ACC_W - PROD_W
) (
    input  mac_pkg::mac_op_e   op,
    input  logic [ACC_W-1:0]   acc_in,
    input  logic [PROD_W-1:0]  prod_lo,
    input  logic [PROD_W-1:0]  prod_hi,
    output logic [ACC_W-1:0]   acc_next
);
    logic [ACC_W-1:0]  ext_lo;
    logic [ACC_W-1:0]  ext_hi;
    logic [ACC_W-1:0]  sum_single;
    logic [ACC_W-1:0]  sum_dual;
    logic [LANE_W-1:0] lane_up;
    logic [LANE_W-1:0] lane_dn;

    // Sign-extend both products to the accumulator width.
    always_comb begin
        ext_lo = {{EXT_W{prod_lo[PROD_W-1]}}, prod_lo};
        ext_hi = {{EXT_W{prod_hi[PROD_W-1]}}, prod_hi};
    end

    // Full-width sums used by the single and dual modes.
    always_comb begin
        sum_single = acc_in + ext_hi;
        sum_dual   = acc_in + ext_hi + ext_lo;
    end

    // Independent lane sums; each adder is only LANE_W wide, so no carry escapes.
    always_comb begin
        lane_up = acc_in[ACC_W-1:LANE_W] + prod_hi[LANE_W-1:0];
        lane_dn = acc_in[LANE_W-1:0]     + prod_lo[LANE_W-1:0];
    end

    // Pick the result for the requested operation.
    always_comb begin
        unique case (op)
            mac_pkg::MAC_OP_SINGLE: acc_next = sum_single;
            mac_pkg::MAC_OP_DUAL:   acc_next = sum_dual;
            mac_pkg::MAC_OP_SIMD:   acc_next = {lane_up, lane_dn};
            default:                acc_next = acc_in;
        endcase
    end
endmodule

// File: rtl/mac_out_reg.sv
// Module: result register with a valid flag.
// It loads on a valid cycle, holds otherwise, and clears on a synchronous
// active-low reset.
module mac_out_reg #(
    parameter int unsigned ACC_W = mac_pkg::MAC_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] d,
    output logic             q_valid,
    output logic [ACC_W-1:0] q
);
    // Capture the new result and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/mac_dual_simd.sv
// Module: top of the dual-multiplier SIMD MAC.
// Path: two parallel multipliers, then the mode combiner, then one result
// register.
// Assumes the caller owns the accumulator storage and feeds it back on acc_in.
module mac_dual_simd #(
    parameter int unsigned HALF_W = mac_pkg::MAC_HALF_W,
    parameter int unsigned ACC_W  = mac_pkg::MAC_ACC_W,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned PROD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [ACC_W-1:0]  acc_in,
    output logic              out_valid,
    output logic [ACC_W-1:0]  acc_out
);
    logic [PROD_W-1:0] prod_lo;
    logic [PROD_W-1:0] prod_hi;
    logic [ACC_W-1:0]  acc_next;
    mac_pkg::mac_op_e  op_sel;

    // Map the raw opcode bits onto the operation type.
    always_comb op_sel = mac_pkg::mac_op_e'(op);

    mac_mul_pair #(.HALF_W(HALF_W)) u_mul (
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .prod_lo (prod_lo),
        .prod_hi (prod_hi)
    );

    mac_combine #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_comb (
        .op       (op_sel),
        .acc_in   (acc_in),
        .prod_lo  (prod_lo),
        .prod_hi  (prod_hi),
        .acc_next (acc_next)
    );

    mac_out_reg #(.ACC_W(ACC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (acc_next),
        .q_valid (out_valid),
        .q       (acc_out)
    );
endmodule

// File: rtl/mac_dual_simd_chk.sv
// Checker: temporal properties of the MAC unit, seen at its ports.
// Every property needs reset released in the sampled cycle before it checks.
module mac_dual_simd_chk #(
    parameter int unsigned HALF_W = mac_pkg::MAC_HALF_W,
    parameter int unsigned ACC_W  = mac_pkg::MAC_ACC_W,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned LANE_W = ACC_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [WORD_W-1:0] opnd_a,
    input logic [WORD_W-1:0] opnd_b,
    input logic [ACC_W-1:0]  acc_in,
    input logic              out_valid,
    input logic [ACC_W-1:0]  acc_out
);
    // R7: a valid request yields out_valid on the next cycle.
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8: an idle cycle holds the result and gives no valid flag.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(acc_out)));

    // R6: the pass opcode returns the accumulator unchanged.
    assert_pass_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> (acc_out == $past(acc_in)));

    // R4: in SIMD mode, with a zero low-half product, the lower lane is unchanged.
    assert_lane_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b10 && opnd_a[HALF_W-1:0] == '0)
        |=> (acc_out[LANE_W-1:0] == $past(acc_in[LANE_W-1:0])));

    // R1: in single mode, a zero high half of a leaves the accumulator unchanged.
    assert_single_zero_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && opnd_a[WORD_W-1:HALF_W] == '0)
        |=> (acc_out == $past(acc_in)));
endmodule

bind mac_dual_simd mac_dual_simd_chk #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/mac_dual_simd_tb.sv
// Bench: walks a vector table through the MAC unit, then runs directed
// reset, hold and back-to-back tests.
module mac_dual_simd_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [39:0] acc_in = '0;
    logic        out_valid;
    logic [39:0] acc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mac_dual_simd u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .acc_in    (acc_in),
        .out_valid (out_valid),
        .acc_out   (acc_out)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [39:0] acc;
        logic [39:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'd1, 2'b00, 32'h0003_0000, 32'h0004_0000, 40'h00_0000_000A, 40'h00_0000_0016}, // R1: 10+3*4
        '{8'd1, 2'b00, 32'hFFFF_0000, 32'h0002_0000, 40'h00_0000_0000, 40'hFF_FFFF_FFFE}, // R1: -1*2
        '{8'd1, 2'b00, 32'h0001_7FFF, 32'h0001_7FFF, 40'h00_0000_0000, 40'h00_0000_0001}, // R1: low halves ignored
        '{8'd2, 2'b01, 32'h0002_0003, 32'h0005_0007, 40'h00_0000_0001, 40'h00_0000_0020}, // R2: 1+10+21
        '{8'd2, 2'b01, 32'h8000_8000, 32'h8000_8000, 40'h00_0000_0000, 40'h00_8000_0000}, // R2: two 2^30
        '{8'd2, 2'b01, 32'hFFFF_0001, 32'h0003_0002, 40'h00_0000_0000, 40'hFF_FFFF_FFFF}, // R2: -3+2
        '{8'd3, 2'b10, 32'h0002_0003, 32'h0004_0005, 40'h00001_00002,  40'h00009_00011},  // R3: lanes 1+8, 2+15
        '{8'd3, 2'b10, 32'h7FFF_0000, 32'h7FFF_0000, 40'h00000_00000,  40'hF0001_00000},  // R3: product truncated to lane
        '{8'd4, 2'b10, 32'h0000_0001, 32'h0000_0001, 40'h00000_FFFFF,  40'h00000_00000},  // R4: lower overflow, no carry
        '{8'd4, 2'b10, 32'h0000_FFFF, 32'h0000_0001, 40'h00005_00000,  40'h00005_FFFFF},  // R4: lower underflow, no borrow
        '{8'd5, 2'b00, 32'h0001_0000, 32'h0001_0000, 40'hFF_FFFF_FFFF, 40'h00_0000_0000}, // R5: wrap mod 2^40
        '{8'd6, 2'b11, 32'h1234_5678, 32'h9ABC_DEF0, 40'h12_3456_789A, 40'h12_3456_789A}  // R6: pass
    };

    task automatic check40(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [39:0] acc);
        @(negedge clk);
        in_valid = 1'b1;
        op = o;
        opnd_a = a;
        opnd_b = b;
        acc_in = acc;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check40("R9 reset acc_out", acc_out, 40'h0);
        check40("R9 reset out_valid", {39'h0, out_valid}, 40'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table, one vector per cycle, sampled after the capturing edge.
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].acc);
            @(posedge clk);
            #1;
            check40($sformatf("R%0d vector %0d", VECS[i].req, i), acc_out, VECS[i].exp);
            check40($sformatf("R7 valid after vector %0d", i), {39'h0, out_valid}, 40'h1);
        end

        // R8: idle cycles hold the result even when the inputs change.
        @(negedge clk);
        in_valid = 1'b0;
        op = 2'b01;
        opnd_a = 32'h7FFF_7FFF;
        opnd_b = 32'h7FFF_7FFF;
        acc_in = 40'h55_5555_5555;
        @(posedge clk);
        #1;
        check40("R8 hold acc_out", acc_out, 40'h12_3456_789A);
        check40("R8 out_valid low", {39'h0, out_valid}, 40'h0);
        @(posedge clk);
        #1;
        check40("R8 hold second cycle", acc_out, 40'h12_3456_789A);

        // R7: back-to-back issue, one result per cycle.
        issue(2'b00, 32'h0002_0000, 32'h0002_0000, 40'h00_0000_0000);
        @(posedge clk);
        #1;
        check40("R7 back-to-back first", acc_out, 40'h00_0000_0004);
        issue(2'b10, 32'h0001_0001, 32'h0001_0001, 40'hFFFFF_FFFFF);
        @(posedge clk);
        #1;
        check40("R7 back-to-back second (R4 both lanes wrap)", acc_out, 40'h00000_00000);
        check40("R7 out_valid stays high", {39'h0, out_valid}, 40'h1);
        idle();
        @(posedge clk);
        #1;
        check40("R7 out_valid drops", {39'h0, out_valid}, 40'h0);

        // R9: a mid-run synchronous reset clears the result.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check40("R9 mid-run reset", acc_out, 40'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule